// File: doc/BRIEF.md
# Sync Header Block Lock Machine

This block sits behind a receive gearbox that delivers 66-bit blocks. With each block it gets a 2-bit synchronization header and a strobe that marks the header as present. From these headers it decides whether the gearbox has found the block boundary. It reports the result on `lock_o`. When the alignment is wrong, it sends a one-cycle `slip_o` request, which tells the gearbox to shift its alignment by one bit.

Gaining lock and losing lock follow different rules. While hunting, a single bad header triggers a slip at once. Lock is declared only after an unbroken run of good headers. Once locked, the block counts headers in fixed windows and drops lock only when too many bad headers land in one window. After each slip, a configurable number of header strobes pass untested so that the gearbox can settle.

Top module: `hdr_lock_top`

## Requirements
- R1: While `rst_n` is low, `lock_o` and `slip_o` are 0, and the machine is hunting with all counts cleared.
- R2: A header is good when `hdr_i` is 2'b01 or 2'b10. The values 2'b00 and 2'b11 are bad.
- R3: While hunting, `lock_o` rises in the cycle after the GOOD_TARGET-th good tested header of an unbroken run, and not before.
- R4: While hunting, a bad tested header raises `slip_o` in the next cycle and discards any partial run of good headers.
- R5: A cycle with `hdr_vld_i` low changes nothing: `lock_o` holds and `slip_o` stays 0.
- R6: After each slip, the next SLIP_WAIT strobed headers are skipped without test. Even a bad one causes no slip and does not count toward lock.
- R7: While locked, up to BAD_LIMIT-1 bad headers inside one window of GOOD_TARGET tested headers leave `lock_o` high.
- R8: While locked, the BAD_LIMIT-th bad header inside a window clears `lock_o` and raises `slip_o` in the same next cycle, and hunting starts over.
- R9: When a window of GOOD_TARGET tested headers completes while locked, the bad count returns to zero for the next window.
- R10: `slip_o` is high for exactly one cycle per slip decision, provided SLIP_WAIT is at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_i | input | 2 | Sync header of the current block |
| hdr_vld_i | input | 1 | High when `hdr_i` carries a header |
| lock_o | output | 1 | Block alignment achieved |
| slip_o | output | 1 | One-cycle request to shift gearbox alignment by one bit |

## Verification
The bench uses a reduced configuration of 4 headers per window, a bad limit of 3 and a hold-off of 2. A directed pass feeds every header code while hunting. This separates the two good codes from the two bad ones and shows that strobes inside the hold-off are skipped. Idle cycles are placed inside a good run to show that they neither break it nor extend it. The locked phase spreads four bad headers across two windows, which tells a per-window count apart from a running count, and then adds a third bad header in one window to force loss of lock. A long pseudo-random sweep mixes strobe gaps with sparse bad headers and compares every cycle against an arithmetic model.

// File: rtl/hdr_lock_pkg.sv
package hdr_lock_pkg;

  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } lock_state_e;

  // A sync header is usable only when its two bits differ.
  function automatic logic sync_hdr_ok(input logic [1:0] hdr);
    return hdr[1] ^ hdr[0];
  endfunction

endpackage

// File: rtl/hdr_lock_classify.sv
module hdr_lock_classify
  import hdr_lock_pkg::*;
(
  input  logic [1:0] hdr_i,
  input  logic       hdr_vld_i,
  input  logic       hold_i,
  output logic       test_o,
  output logic       good_o
);

  always_comb begin
    test_o = hdr_vld_i & ~hold_i;
    good_o = sync_hdr_ok(hdr_i);
  end

endmodule

// File: rtl/hdr_lock_holdoff.sv
module hdr_lock_holdoff #(
  parameter int SLIP_WAIT = 32,
  parameter int WAIT_W    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic strobe_i,
  output logic busy_o
);

  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              wait_en;

  always_comb begin
    wait_en = 1'b0;
    wait_d  = wait_q;
    if (load_i) begin
      wait_en = 1'b1;
      wait_d  = WAIT_W'(SLIP_WAIT);
    end else if (strobe_i && (wait_q != '0)) begin
      wait_en = 1'b1;
      wait_d  = wait_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_q <= '0;
    else if (wait_en) wait_q <= wait_d;
  end

  assign busy_o = (wait_q != '0);

endmodule

// File: rtl/hdr_lock_window.sv
module hdr_lock_window #(
  parameter int GOOD_TARGET = 64,
  parameter int BAD_LIMIT   = 16,
  parameter int CNT_W       = 7,
  parameter int BAD_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             bad_i,
  input  logic             clr_i,
  output logic             win_full_o,
  output logic             bad_full_o,
  output logic             clean_o,
  output logic [BAD_W-1:0] bad_cnt_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GOOD_TARGET - 1);
  localparam logic [BAD_W-1:0] BAD_LAST = BAD_W'(BAD_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BAD_W-1:0] bad_q, bad_d;
  logic             cnt_en;

  always_comb begin
    win_full_o = step_i && (cnt_q == CNT_LAST);
    bad_full_o = step_i && bad_i && (bad_q == BAD_LAST);
    clean_o    = (bad_q == '0);
  end

  always_comb begin
    cnt_en = clr_i | step_i;
    cnt_d  = cnt_q;
    bad_d  = bad_q;
    if (clr_i || win_full_o) begin
      cnt_d = '0;
      bad_d = '0;
    end else if (step_i) begin
      cnt_d = cnt_q + 1'b1;
      bad_d = bad_q + BAD_W'(bad_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bad_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      bad_q <= bad_d;
    end
  end

  assign bad_cnt_o = bad_q;

endmodule

// File: rtl/hdr_lock_top.sv
module hdr_lock_top
  import hdr_lock_pkg::*;
#(
  parameter int GOOD_TARGET = 64,
  parameter int BAD_LIMIT   = 16,
  parameter int SLIP_WAIT   = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hdr_i,
  input  logic       hdr_vld_i,
  output logic       lock_o,
  output logic       slip_o
);

  localparam int CNT_W  = $clog2(GOOD_TARGET + 1);
  localparam int BAD_W  = $clog2(BAD_LIMIT + 1);
  localparam int WAIT_W = $clog2(SLIP_WAIT + 2);

  lock_state_e      state_q, state_d;
  logic             slip_q, slip_d;
  logic             test, good, hold_busy, win_clr;
  logic             win_full, bad_full, clean;
  logic [BAD_W-1:0] bad_cnt;

  hdr_lock_classify u_classify (
    .hdr_i     (hdr_i),
    .hdr_vld_i (hdr_vld_i),
    .hold_i    (hold_busy),
    .test_o    (test),
    .good_o    (good)
  );

  hdr_lock_holdoff #(
    .SLIP_WAIT (SLIP_WAIT),
    .WAIT_W    (WAIT_W)
  ) u_holdoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (slip_d),
    .strobe_i (hdr_vld_i),
    .busy_o   (hold_busy)
  );

  hdr_lock_window #(
    .GOOD_TARGET (GOOD_TARGET),
    .BAD_LIMIT   (BAD_LIMIT),
    .CNT_W       (CNT_W),
    .BAD_W       (BAD_W)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (test),
    .bad_i      (~good),
    .clr_i      (win_clr),
    .win_full_o (win_full),
    .bad_full_o (bad_full),
    .clean_o    (clean),
    .bad_cnt_o  (bad_cnt)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    slip_d  = 1'b0;
    win_clr = 1'b0;
    if (test) begin
      unique case (state_q)
        ST_HUNT: begin
          if (!good) begin
            slip_d  = 1'b1;
            win_clr = 1'b1;
          end else if (win_full && clean) begin
            state_d = ST_LOCKED;
          end
        end
        ST_LOCKED: begin
          if (bad_full) begin
            state_d = ST_HUNT;
            slip_d  = 1'b1;
            win_clr = 1'b1;
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      slip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slip_q  <= slip_d;
    end
  end

  assign lock_o = (state_q == ST_LOCKED);
  assign slip_o = slip_q;

endmodule

// File: rtl/hdr_lock_chk.sv
module hdr_lock_chk #(
  parameter int BAD_LIMIT = 16,
  parameter int BAD_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       hdr_i,
  input logic             hdr_vld_i,
  input logic             lock_o,
  input logic             slip_o,
  input logic             hold_busy,
  input logic [BAD_W-1:0] bad_cnt
);

  p_slip_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |=> !slip_o);

  p_slip_only_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |-> !lock_o);

  p_lock_drop_slips_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> slip_o);

  p_idle_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_vld_i |=> ($stable(lock_o) && !slip_o));

  p_lock_rise_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> ($past(hdr_vld_i) && ($past(hdr_i) inside {2'b01, 2'b10})));

  p_holdoff_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |=> !slip_o);

  p_bad_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bad_cnt) < BAD_LIMIT);

endmodule

bind hdr_lock_top hdr_lock_chk #(
  .BAD_LIMIT (BAD_LIMIT),
  .BAD_W     (BAD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hdr_i     (hdr_i),
  .hdr_vld_i (hdr_vld_i),
  .lock_o    (lock_o),
  .slip_o    (slip_o),
  .hold_busy (hold_busy),
  .bad_cnt   (bad_cnt)
);

// File: tb/hdr_lock_top_test.sv
module hdr_lock_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int G = 4;
  localparam int B = 3;
  localparam int W = 2;
  localparam int WATCHDOG = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] hdr;
  logic       vld;
  logic       lock, slip;

  int n_checks = 0;
  int n_errs   = 0;
  int cyc      = 0;
  int seen_lock = 0;
  int seen_slip = 0;

  // Bench model state
  int m_lock, m_slip, m_cnt, m_bad, m_wait;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_lock_top #(
    .GOOD_TARGET (G),
    .BAD_LIMIT   (B),
    .SLIP_WAIT   (W)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_i     (hdr),
    .hdr_vld_i (vld),
    .lock_o    (lock),
    .slip_o    (slip)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_errs++;
      $display("FAIL R10 watchdog: actual %0d cycles, expected below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual %0d, expected %0d", tag, act, exp);
    end
  endtask

  // Expected behaviour for one clock edge, written from the requirements.
  task automatic model_edge(input bit v, input logic [1:0] h);
    bit good;
    m_slip = 0;
    if (!v) return;
    if (m_wait > 0) begin
      m_wait--;
      return;
    end
    good = (h == 2'b01) || (h == 2'b10);
    if (m_lock == 0) begin
      if (!good) begin
        m_slip = 1; m_cnt = 0; m_bad = 0; m_wait = W;
      end else begin
        m_cnt++;
        if (m_cnt == G) begin m_lock = 1; m_cnt = 0; end
      end
    end else begin
      m_cnt++;
      if (!good) m_bad++;
      if (m_bad == B) begin
        m_lock = 0; m_slip = 1; m_cnt = 0; m_bad = 0; m_wait = W;
      end else if (m_cnt == G) begin
        m_cnt = 0; m_bad = 0;
      end
    end
  endtask

  // Drive at negedge, let one posedge pass, compare at the next negedge.
  task automatic drive(input bit v, input logic [1:0] h);
    vld = v;
    hdr = h;
    @(posedge clk);
    model_edge(v, h);
    @(negedge clk);
    check("R3 model lock", int'(lock), m_lock);
    check("R10 model slip", int'(slip), m_slip);
    if (lock) seen_lock++;
    if (slip) seen_slip++;
  endtask

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0;
    vld   = 1'b0;
    hdr   = 2'b00;
    m_lock = 0; m_slip = 0; m_cnt = 0; m_bad = 0; m_wait = 0;
    repeat (3) @(negedge clk);
    check("R1 reset lock", int'(lock), 0);
    check("R1 reset slip", int'(slip), 0);
    rst_n = 1'b1;

    // Hunting: every header code once
    drive(1'b1, 2'b01); check("R2 code 01 good", int'(slip), 0);
    drive(1'b1, 2'b10); check("R2 code 10 good", int'(slip), 0);
    drive(1'b1, 2'b00); check("R4 code 00 bad slips", int'(slip), 1);
    drive(1'b0, 2'b00); check("R10 slip one cycle", int'(slip), 0);
    drive(1'b1, 2'b11); check("R6 hold-off skip 1", int'(slip), 0);
    drive(1'b1, 2'b11); check("R6 hold-off skip 2", int'(slip), 0);
    drive(1'b1, 2'b11); check("R2 code 11 bad slips", int'(slip), 1);
    drive(1'b1, 2'b01); check("R6 good in hold-off", int'(lock), 0);
    drive(1'b1, 2'b10); check("R6 good in hold-off", int'(lock), 0);

    // Good run with idle gaps
    drive(1'b1, 2'b01);
    drive(1'b0, 2'b11); check("R5 idle no slip", int'(slip), 0);
    drive(1'b1, 2'b10);
    drive(1'b1, 2'b01); check("R4 run restarted, not locked yet", int'(lock), 0);
    drive(1'b0, 2'b00); check("R5 idle keeps unlocked", int'(lock), 0);
    drive(1'b1, 2'b10); check("R3 lock after full run", int'(lock), 1);

    // Locked: bad headers spread over two windows
    drive(1'b1, 2'b00); check("R7 first bad keeps lock", int'(lock), 1);
    drive(1'b1, 2'b11); check("R7 second bad keeps lock", int'(lock), 1);
    drive(1'b0, 2'b00); check("R5 idle keeps lock", int'(lock), 1);
    drive(1'b1, 2'b01);
    drive(1'b1, 2'b10); check("R9 window end keeps lock", int'(lock), 1);
    drive(1'b1, 2'b00);
    drive(1'b1, 2'b11); check("R9 bad count restarted", int'(lock), 1);
    check("R7 no slip while locked", int'(slip), 0);
    drive(1'b1, 2'b00);
    check("R8 limit reached drops lock", int'(lock), 0);
    check("R8 limit reached slips", int'(slip), 1);
    drive(1'b0, 2'b00); check("R10 slip one cycle after unlock", int'(slip), 0);

    // Pseudo-random sweep
    lf = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] h;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      h = (lf[8:6] == 3'b000) ? {lf[3], lf[3]} : {lf[4], ~lf[4]};
      drive(lf[1:0] != 2'b00, h);
    end
    check("R3 sweep reached lock", int'(seen_lock > 0), 1);
    check("R4 sweep produced slips", int'(seen_slip > 0), 1);

    summary();
    $finish;
  end

endmodule